// File: doc/BRIEF.md
# Framed Serial Command Receiver

This block is the serial front end of a single-channel converter. It watches a three-wire slave port (an active-low select, a serial clock and a data line). The block samples all three in its own system clock domain and assembles one fixed-length frame for each select assertion. A frame is an 8-bit command followed by 16 data bits, most significant bit first. When the last bit arrives, the block presents the command and data to downstream decode logic together with a strobe that lasts one system clock.

After a full frame, the block ignores any further serial clock edges while the select is still low. It also pulls its chain output low, so that output can act as the select of the next device that shares the clock and data lines. A frame cut short by the select rising is thrown away. The chain output can be disabled, and it then stays high.

Top module: `dac_serial_rx`

## Requirements
- R1: The first bit after select falls lands in `frm_cmd[7]` and the 24th bit lands in `frm_data[0]`. Bits 1 to 8 form `frm_cmd` and bits 9 to 24 form `frm_data`, each most significant bit first.
- R2: `frm_valid` is high for exactly one system clock per complete frame. It rises a few system clocks after the 24th falling edge of the serial clock, and never on two consecutive cycles.
- R3: Serial clock falling edges after the 24th, within the same select assertion, cause no strobe and leave `frm_cmd`/`frm_data` unchanged.
- R4: If select rises before 24 bits have been received, no strobe is issued and `frm_cmd`/`frm_data` keep the previous frame.
- R5: Every select falling edge restarts bit counting, so a complete frame that follows a truncated one is assembled correctly.
- R6: `rdy_out` is high after reset. With `rdy_en`=1 it goes low after the 24th falling edge, stays low while select is low, and returns high after select rises.
- R7: While `rdy_en`=0, `rdy_out` stays high.
- R8: Frames are received correctly whether the serial clock idles high or low between frames.
- R9: After reset, `frm_valid`=0, `frm_cmd`=0, `frm_data`=0 and `rdy_out`=1.
- R10: Serial clock edges while select is high produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select, asynchronous |
| sclk | input | 1 | Serial clock, data taken on its falling edge, asynchronous |
| sdi | input | 1 | Serial data in, asynchronous |
| rdy_en | input | 1 | 1 enables the chain output, 0 holds it high |
| frm_valid | output | 1 | One-cycle strobe for a completed frame |
| frm_cmd | output | 8 | Command byte of the last completed frame |
| frm_data | output | 16 | Data word of the last completed frame |
| rdy_out | output | 1 | Chain output, low after a complete frame until select rises |

## Verification
The assertions assume that select, clock and data are steady for at least two system clocks around every serial clock edge. They also assume that select never falls in the same synchronized sample as a serial clock falling edge. The bench meets these assumptions by driving every pin on the falling edge of the system clock. Each serial clock phase lasts four system clocks, data is set while the clock is high, and select changes only when the clock has been still for four cycles.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    localparam int DSR_CMD_BITS  = 8;
    localparam int DSR_DATA_BITS = 16;
    localparam int DSR_SYNC      = 2;

    function automatic logic fell(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction
endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= RST_VAL;
            end
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/dsr_framer.sv
module dsr_framer #(
    parameter int FRAME_BITS = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_s,
    input  logic                  sclk_s,
    input  logic                  sdi_s,
    output logic                  frame_valid,
    output logic [FRAME_BITS-1:0] frame_word,
    output logic                  frame_full
);
    import dsr_pkg::*;

    localparam int              CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(FRAME_BITS);

    typedef struct packed {
        logic                  cs_prev;
        logic                  sclk_prev;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] shreg;
        logic                  valid;
        logic [FRAME_BITS-1:0] frame;
    } fr_state_t;

    fr_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.valid     = 1'b0;
        st_d.cs_prev   = cs_s;
        st_d.sclk_prev = sclk_s;
        if (cs_s || fell(st_q.cs_prev, cs_s)) begin
            st_d.cnt   = '0;
            st_d.shreg = '0;
        end else if (fell(st_q.sclk_prev, sclk_s) && (st_q.cnt < FULL)) begin
            st_d.shreg = {st_q.shreg[FRAME_BITS-2:0], sdi_s};
            st_d.cnt   = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == LAST) begin
                st_d.valid = 1'b1;
                st_d.frame = {st_q.shreg[FRAME_BITS-2:0], sdi_s};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cs_prev   <= 1'b1;
            st_q.sclk_prev <= 1'b0;
            st_q.cnt       <= '0;
            st_q.shreg     <= '0;
            st_q.valid     <= 1'b0;
            st_q.frame     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_valid = st_q.valid;
    assign frame_word  = st_q.frame;
    assign frame_full  = (st_q.cnt == FULL);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        st_q.valid |=> !st_q.valid); // R2
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> !st_q.valid); // R10
    AST_FULL_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (frame_full && !cs_s) |=> (!st_q.valid && $stable(st_q.frame))); // R3
endmodule

// File: rtl/dsr_ready.sv
module dsr_ready (
    input  logic clk,
    input  logic rst,
    input  logic rdy_en,
    input  logic cs_s,
    input  logic frame_full,
    output logic rdy
);
    logic rdy_d, rdy_q;

    always_comb begin
        rdy_d = !(rdy_en && !cs_s && frame_full);
    end

    always_ff @(posedge clk) begin
        if (rst) rdy_q <= 1'b1;
        else     rdy_q <= rdy_d;
    end

    assign rdy = rdy_q;

    AST_RDY_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !rdy_en |=> rdy_q); // R7
    AST_RDY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> rdy_q); // R6
endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx #(
    parameter int CMD_BITS    = dsr_pkg::DSR_CMD_BITS,
    parameter int DATA_BITS   = dsr_pkg::DSR_DATA_BITS,
    parameter int SYNC_STAGES = dsr_pkg::DSR_SYNC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 sclk,
    input  logic                 sdi,
    input  logic                 rdy_en,
    output logic                 frm_valid,
    output logic [CMD_BITS-1:0]  frm_cmd,
    output logic [DATA_BITS-1:0] frm_data,
    output logic                 rdy_out
);
    localparam int FRAME_BITS = CMD_BITS + DATA_BITS;

    logic [2:0]            pins_s;
    logic                  full;
    logic [FRAME_BITS-1:0] word;

    dsr_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({cs_n, sclk, sdi}),
        .dout(pins_s)
    );

    dsr_framer #(
        .FRAME_BITS(FRAME_BITS)
    ) u_framer (
        .clk        (clk),
        .rst        (rst),
        .cs_s       (pins_s[2]),
        .sclk_s     (pins_s[1]),
        .sdi_s      (pins_s[0]),
        .frame_valid(frm_valid),
        .frame_word (word),
        .frame_full (full)
    );

    dsr_ready u_ready (
        .clk       (clk),
        .rst       (rst),
        .rdy_en    (rdy_en),
        .cs_s      (pins_s[2]),
        .frame_full(full),
        .rdy       (rdy_out)
    );

    assign frm_cmd  = word[FRAME_BITS-1 -: CMD_BITS];
    assign frm_data = word[DATA_BITS-1:0];

    AST_FRAME_HELD: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |-> $stable({frm_cmd, frm_data})); // R4
endmodule

// File: tb/dac_serial_rx_tb.sv
`timescale 1ns/1ps
module dac_serial_rx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        rdy_en = 1'b1;
    logic        frm_valid;
    logic [7:0]  frm_cmd;
    logic [15:0] frm_data;
    logic        rdy_out;

    int errors = 0;
    int checks = 0;
    int strobes = 0;
    bit finished = 1'b0;
    logic [23:0] expq[$];

    always #2.5 clk = ~clk;

    dac_serial_rx u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .rdy_en(rdy_en), .frm_valid(frm_valid), .frm_cmd(frm_cmd),
        .frm_data(frm_data), .rdy_out(rdy_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: pushes the expected frame, then clocks out nbits bits.
    task automatic send(input logic [23:0] word, input int nbits, input bit idle_hi);
        sclk = idle_hi;
        wait_cyc(4);
        if (nbits >= 24) expq.push_back(word);
        cs_n = 1'b0;
        wait_cyc(4);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1;
            sdi  = (i < 24) ? word[23-i] : i[0];
            wait_cyc(4);
            sclk = 1'b0;
            wait_cyc(4);
        end
        sclk = idle_hi;
        wait_cyc(4);
    endtask

    task automatic end_frame();
        cs_n = 1'b1;
        wait_cyc(8);
    endtask

    // Monitor: pops expected frames as strobes appear.
    initial begin
        logic prev_v = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (frm_valid && prev_v) check("R2 strobe width", 32'd2, 32'd1);
                if (frm_valid) begin
                    strobes++;
                    if (expq.size() == 0) begin
                        check("R2 unexpected strobe", 32'd1, 32'd0);
                    end else begin
                        logic [23:0] e;
                        e = expq.pop_front();
                        check("R1 cmd", {24'd0, frm_cmd}, {24'd0, e[23:16]});
                        check("R1 data", {16'd0, frm_data}, {16'd0, e[15:0]});
                    end
                end
                prev_v = frm_valid;
            end
        end
    end

    initial begin
        int s0;
        logic [23:0] last;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);
        // R9 reset state
        check("R9 valid", {31'd0, frm_valid}, 32'd0);
        check("R9 cmd", {24'd0, frm_cmd}, 32'd0);
        check("R9 data", {16'd0, frm_data}, 32'd0);
        check("R9 rdy", {31'd0, rdy_out}, 32'd1);

        // R1/R2/R6: plain frame, idle low
        s0 = strobes;
        send(24'hA5_1234, 24, 1'b0);
        check("R6 rdy low after frame", {31'd0, rdy_out}, 32'd0);
        end_frame();
        check("R6 rdy high after cs rise", {31'd0, rdy_out}, 32'd1);
        check("R2 one strobe", strobes - s0, 32'd1);

        // R8: idle high clock
        s0 = strobes;
        send(24'h3C_F00F, 24, 1'b1);
        end_frame();
        check("R8 idle-high strobe", strobes - s0, 32'd1);
        send(24'hFF_FFFF, 24, 1'b1);
        end_frame();
        send(24'h00_0001, 24, 1'b0);
        end_frame();

        // R3: extra bits ignored
        s0 = strobes;
        send(24'h55_AAAA, 31, 1'b0);
        check("R3 single strobe", strobes - s0, 32'd1);
        check("R3 data kept", {8'd0, frm_cmd, frm_data}, {8'd0, 24'h55_AAAA});
        check("R6 rdy low during extra bits", {31'd0, rdy_out}, 32'd0);
        end_frame();

        // R4: truncated frame dropped
        last = {frm_cmd, frm_data};
        s0 = strobes;
        send(24'h12_3456, 10, 1'b0);
        check("R6 rdy high in partial", {31'd0, rdy_out}, 32'd1);
        end_frame();
        check("R4 no strobe", strobes - s0, 32'd0);
        check("R4 outputs held", {8'd0, frm_cmd, frm_data}, {8'd0, last});

        // R5: full frame after truncation
        s0 = strobes;
        send(24'h81_7E18, 24, 1'b1);
        end_frame();
        check("R5 restart strobe", strobes - s0, 32'd1);

        // R10: clock toggles while deselected
        s0 = strobes;
        for (int k = 0; k < 30; k++) begin
            sclk = 1'b1; sdi = k[0]; wait_cyc(4);
            sclk = 1'b0; wait_cyc(4);
        end
        check("R10 no strobe", strobes - s0, 32'd0);

        // R7: ready disabled
        rdy_en = 1'b0;
        wait_cyc(2);
        send(24'h03_0000, 26, 1'b0);
        check("R7 rdy held high", {31'd0, rdy_out}, 32'd1);
        end_frame();
        rdy_en = 1'b1;
        wait_cyc(4);

        check("R2 queue drained", expq.size(), 32'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule